// File: doc/BRIEF.md
# Bit-Serial One-Bit Arithmetic Logic Unit

This block processes operand words one bit per accepted step. Every step combines up to three bits: the bit on the one-bit data input, the bit held in the result register, and the carry bit left by an earlier step. A 4-bit operation code picks the function. The functions are loads, logic operations, add, add-complement, carry set, carry clear and a flag strobe. All state changes on the falling edge of the clock, and reset is synchronous.

Multi-bit arithmetic is driven from outside, least significant bit first. For each bit position the controller first loads the first operand's bit into the result register and then issues add, or add-complement, with the second operand's bit. The sum bit appears on `res_bit`. The carry register passes the carry from one bit position to the next, because load operations never touch it. To subtract in two's complement, the controller sets the carry once, before the lowest bit, and then uses add-complement for every bit.

Steps arrive on a valid/ready handshake. A step is taken on a falling edge where `op_valid` and `op_ready` are both high. `op_ready` is low only while reset is asserted. A source that sees `op_ready` low must hold its step until `op_ready` returns. The block never stalls a step in any other case, and it produces no output stream that could apply back-pressure.

Top module: `alu1_serial`

## Requirements
- R1: A falling edge with `rst` high clears `res_bit`, `carry_bit`, `flag_strobe` and `carry_oe` to 0 and discards any offered step. `op_ready` is low while `rst` is high.
- R2: Op code 1 loads the data bit into the result register. Op code 2 loads its inverse. Neither changes the carry register.
- R3: Op codes 3, 4, 5, 6, 7 and 8 replace the result bit with, in order: result AND data, result AND NOT data, result OR data, result OR NOT data, result XNOR data, and result XOR data. None of them changes the carry register.
- R4: Op code 9 (add) writes result XOR data XOR carry to the result register, and writes the majority of those three bits to the carry register.
- R5: Op code 10 (add-complement) behaves like op code 9, but uses the inverted data bit.
- R6: Op code 11 sets the carry register to 1 and op code 12 clears it. The result register keeps its value.
- R7: For 8-bit operands sent LSB first as load/add pairs after a carry clear, the result bits form (A+B) mod 256 and the final carry equals the bit 8 of A+B. After a carry set, with add-complement, the result bits form (A−B) mod 256 and the final carry is 1 exactly when A ≥ B.
- R8: Add-complement with result 0 and carry 0 leaves the inverse of the data bit in the result register.
- R9: Op code 13 raises `flag_strobe[flag_sel]` for exactly one cycle. At most one strobe bit is ever high, and all strobe bits are low after any other step.
- R10: `carry_oe` is high for the cycle after an accepted add or add-complement step, and low after every other step.
- R11: A falling edge without an accepted step leaves the result and carry registers unchanged, and it drops `flag_strobe` and `carry_oe` to 0. Op codes 0, 14 and 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | A step is offered |
| op_ready | output | 1 | The block can take a step (low during reset) |
| op_code | input | 4 | Operation code of the offered step |
| bus_bit | input | 1 | Data bit of the offered step |
| flag_sel | input | FLAG_SEL_W | Strobe index used by op code 13 |
| res_bit | output | 1 | Result register |
| carry_bit | output | 1 | Carry register |
| flag_strobe | output | 2**FLAG_SEL_W | One-hot flag strobes |
| carry_oe | output | 1 | Last step wrote both result and carry |

## Verification
The hardest condition to reach from the ports is a carry that has to survive through a chain of loads and arithmetic steps across all eight bit positions. Operand pairs such as 255+1 and 0−1 ripple a carry through every position, so a single stray write to the carry register would corrupt the high bits. The stimulus therefore interleaves load and arithmetic steps exactly as a controller would issue them, and the bench compares the gathered result bits and the final carry against integer arithmetic. Single-step vectors first preset the result and carry registers through the normal operations, so that every function is reached from chosen starting states.

// File: rtl/alu1_pkg.sv
package alu1_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LD   = 4'd1,
    OP_LDC  = 4'd2,
    OP_AND  = 4'd3,
    OP_ANDC = 4'd4,
    OP_OR   = 4'd5,
    OP_ORC  = 4'd6,
    OP_XNOR = 4'd7,
    OP_XOR  = 4'd8,
    OP_ADD  = 4'd9,
    OP_ADDC = 4'd10,
    OP_SETC = 4'd11,
    OP_CLRC = 4'd12,
    OP_FLAG = 4'd13
  } alu1_op_e;

  // Per-step register writes and side-channel requests
  typedef struct packed {
    logic rr_we;
    logic rr_d;
    logic cy_we;
    logic cy_d;
    logic flag_en;
    logic both_we;
  } alu1_ctl_t;

endpackage

// File: rtl/alu1_fu.sv
module alu1_fu
  import alu1_pkg::*;
(
  input  logic [3:0] op_code,
  input  logic       bus_bit,
  input  logic       rr_q,
  input  logic       cy_q,
  output alu1_ctl_t  ctl
);

  logic     operand;
  logic     sum_b;
  logic     maj_b;
  alu1_op_e op;

  assign op = alu1_op_e'(op_code);

  // Complement variants invert the data bit before it reaches the gates
  always_comb begin
    case (op)
      OP_LDC, OP_ANDC, OP_ORC, OP_ADDC: operand = ~bus_bit;
      default:                          operand = bus_bit;
    endcase
  end

  // Full adder slice shared by add and add-complement
  assign sum_b = rr_q ^ operand ^ cy_q;
  assign maj_b = (rr_q & operand) | (rr_q & cy_q) | (operand & cy_q);

  always_comb begin
    ctl = '0;
    case (op)
      OP_LD, OP_LDC: begin
        ctl.rr_we = 1'b1;
        ctl.rr_d  = operand;
      end
      OP_AND, OP_ANDC: begin
        ctl.rr_we = 1'b1;
        ctl.rr_d  = rr_q & operand;
      end
      OP_OR, OP_ORC: begin
        ctl.rr_we = 1'b1;
        ctl.rr_d  = rr_q | operand;
      end
      OP_XNOR: begin
        ctl.rr_we = 1'b1;
        ctl.rr_d  = ~(rr_q ^ operand);
      end
      OP_XOR: begin
        ctl.rr_we = 1'b1;
        ctl.rr_d  = rr_q ^ operand;
      end
      OP_ADD, OP_ADDC: begin
        ctl.rr_we   = 1'b1;
        ctl.rr_d    = sum_b;
        ctl.cy_we   = 1'b1;
        ctl.cy_d    = maj_b;
        ctl.both_we = 1'b1;
      end
      OP_SETC: begin
        ctl.cy_we = 1'b1;
        ctl.cy_d  = 1'b1;
      end
      OP_CLRC: begin
        ctl.cy_we = 1'b1;
        ctl.cy_d  = 1'b0;
      end
      OP_FLAG: ctl.flag_en = 1'b1;
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/alu1_flag_dec.sv
module alu1_flag_dec #(
  parameter int SEL_W = 3,
  localparam int N_OUT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N_OUT-1:0] strobe
);

  for (genvar g = 0; g < N_OUT; g++) begin : g_line
    assign strobe[g] = en && (sel == SEL_W'(g));
  end

endmodule

// File: rtl/alu1_serial.sv
module alu1_serial
  import alu1_pkg::*;
#(
  parameter int FLAG_SEL_W = 3,
  localparam int N_FLAGS = 1 << FLAG_SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic [3:0]            op_code,
  input  logic                  bus_bit,
  input  logic [FLAG_SEL_W-1:0] flag_sel,
  output logic                  res_bit,
  output logic                  carry_bit,
  output logic [N_FLAGS-1:0]    flag_strobe,
  output logic                  carry_oe
);

  alu1_ctl_t          ctl;
  logic [N_FLAGS-1:0] dec_strobe;
  logic               take;
  logic               rr_q;
  logic               cy_q;
  logic [N_FLAGS-1:0] flag_q;
  logic               coe_q;

  assign op_ready = ~rst;
  assign take     = op_valid & op_ready;

  alu1_fu u_fu (
    .op_code (op_code),
    .bus_bit (bus_bit),
    .rr_q    (rr_q),
    .cy_q    (cy_q),
    .ctl     (ctl)
  );

  alu1_flag_dec #(.SEL_W(FLAG_SEL_W)) u_dec (
    .en     (ctl.flag_en),
    .sel    (flag_sel),
    .strobe (dec_strobe)
  );

  // All state moves on the falling edge
  always_ff @(negedge clk) begin
    if (rst) begin
      rr_q   <= 1'b0;
      cy_q   <= 1'b0;
      flag_q <= '0;
      coe_q  <= 1'b0;
    end else begin
      flag_q <= take ? dec_strobe : '0;
      coe_q  <= take & ctl.both_we;
      if (take && ctl.rr_we) rr_q <= ctl.rr_d;
      if (take && ctl.cy_we) cy_q <= ctl.cy_d;
    end
  end

  assign res_bit     = rr_q;
  assign carry_bit   = cy_q;
  assign flag_strobe = flag_q;
  assign carry_oe    = coe_q;

  // R1: reset clears every register
  a_r1_reset_clear: assert property (@(negedge clk)
    rst |=> (!rr_q && !cy_q && flag_q == '0 && !coe_q));

  // R1: no readiness while in reset
  a_r1_not_ready: assert property (@(negedge clk)
    rst |-> !op_ready);

  // R2, R3: loads and logic operations keep the carry
  a_r3_carry_kept: assert property (@(negedge clk) disable iff (rst)
    (take && op_code >= 4'd1 && op_code <= 4'd8) |=> $stable(cy_q));

  // R6: carry set and clear
  a_r6_setc: assert property (@(negedge clk) disable iff (rst)
    (take && op_code == 4'd11) |=> (cy_q && $stable(rr_q)));
  a_r6_clrc: assert property (@(negedge clk) disable iff (rst)
    (take && op_code == 4'd12) |=> (!cy_q && $stable(rr_q)));

  // R9: at most one strobe
  a_r9_onehot: assert property (@(negedge clk) disable iff (rst)
    $onehot0(flag_q));

  // R10: both-register writes flagged after arithmetic only
  a_r10_coe: assert property (@(negedge clk) disable iff (rst)
    take |=> (coe_q == ($past(op_code) == 4'd9 || $past(op_code) == 4'd10)));

  // R11: idle edges hold state
  a_r11_idle: assert property (@(negedge clk) disable iff (rst)
    !take |=> ($stable(rr_q) && $stable(cy_q) && flag_q == '0 && !coe_q));

endmodule

// File: tb/alu1_serial_test.sv
module alu1_serial_test;

  localparam int CYC = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic       op_ready;
  logic [3:0] op_code;
  logic       bus_bit;
  logic [2:0] flag_sel;
  logic       res_bit;
  logic       carry_bit;
  logic [7:0] flag_strobe;
  logic       carry_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CYC/2) clk = ~clk;

  alu1_serial #(.FLAG_SEL_W(3)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .bus_bit(bus_bit), .flag_sel(flag_sel),
    .res_bit(res_bit), .carry_bit(carry_bit), .flag_strobe(flag_strobe),
    .carry_oe(carry_oe)
  );

  // [8:5] op, [4] result preset, [3] carry preset, [2] data, [1] result, [0] carry
  localparam logic [8:0] VEC [17] = '{
    9'b0001_011_11, 9'b0010_101_00, 9'b0011_110_01, 9'b0011_101_10,
    9'b0100_100_10, 9'b0101_011_11, 9'b0110_001_00, 9'b0111_101_10,
    9'b0111_011_01, 9'b1000_111_01, 9'b1001_111_11, 9'b1001_100_10,
    9'b1001_011_01, 9'b1010_001_00, 9'b1010_000_10, 9'b1010_110_11,
    9'b1010_101_10
  };

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic b,
                     input logic [2:0] fs = 3'd0, input logic v = 1'b1);
    @(posedge clk); #2;
    op_code = op; bus_bit = b; flag_sel = fs; op_valid = v;
    @(negedge clk); #2;
    op_valid = 1'b0;
  endtask

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd2)  return "R2";
    if (op <= 4'd8)  return "R3";
    if (op == 4'd9)  return "R4";
    return "R5";
  endfunction

  task automatic serial8(input logic [7:0] a, input logic [7:0] b, input bit sub);
    logic [7:0] got;
    logic [8:0] ref_v;
    step(sub ? 4'd11 : 4'd12, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(4'd1, a[i]);
      step(sub ? 4'd10 : 4'd9, b[i]);
      got[i] = res_bit;
    end
    ref_v = sub ? {1'b0, a - b} : 9'(a) + 9'(b);
    check(sub ? "R7 difference" : "R7 sum", int'(got), int'(ref_v[7:0]));
    check("R7 final carry", int'(carry_bit), sub ? int'(a >= b) : int'(ref_v[8]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_code = '0; bus_bit = 1'b0; flag_sel = '0;
    repeat (3) @(negedge clk);
    #2;
    check("R1 result after reset", int'(res_bit), 0);
    check("R1 carry after reset", int'(carry_bit), 0);
    check("R1 strobes after reset", int'(flag_strobe), 0);
    check("R1 carry_oe after reset", int'(carry_oe), 0);
    check("R1 ready low in reset", int'(op_ready), 0);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk); #2;
    check("R1 ready after reset", int'(op_ready), 1);

    // Single-step vectors, presets made through normal operations
    foreach (VEC[k]) begin
      step(4'd1, VEC[k][4]);
      step(VEC[k][3] ? 4'd11 : 4'd12, 1'b0);
      step(VEC[k][8:5], VEC[k][2]);
      check({tag_of(VEC[k][8:5]), " result"}, int'(res_bit), int'(VEC[k][1]));
      check({tag_of(VEC[k][8:5]), " carry"}, int'(carry_bit), int'(VEC[k][0]));
      check("R10 carry_oe", int'(carry_oe),
            int'(VEC[k][8:5] == 4'd9 || VEC[k][8:5] == 4'd10));
      check("R9 no strobe", int'(flag_strobe), 0);
    end

    // R8: complement into a cleared result
    for (int b = 0; b < 2; b++) begin
      step(4'd1, 1'b0);
      step(4'd12, 1'b0);
      step(4'd10, 1'(b));
      check("R8 inverse", int'(res_bit), 1 - b);
    end

    // R6: carry set and clear keep the result
    step(4'd1, 1'b1);
    step(4'd11, 1'b0);
    check("R6 set carry", int'(carry_bit), 1);
    check("R6 result kept", int'(res_bit), 1);
    step(4'd12, 1'b1);
    check("R6 clear carry", int'(carry_bit), 0);

    // R9: every strobe line, one cycle wide
    for (int s = 0; s < 8; s++) begin
      step(4'd13, 1'b0, 3'(s));
      check("R9 strobe", int'(flag_strobe), 1 << s);
      check("R10 no carry_oe on flag", int'(carry_oe), 0);
      @(negedge clk); #2;
      check("R9 strobe drops", int'(flag_strobe), 0);
    end

    // R11: unaccepted steps and no-op codes change nothing
    step(4'd1, 1'b1);
    step(4'd11, 1'b0);
    step(4'd12, 1'b0, 3'd0, 1'b0);
    step(4'd1, 1'b0, 3'd0, 1'b0);
    check("R11 result held", int'(res_bit), 1);
    check("R11 carry held", int'(carry_bit), 1);
    step(4'd14, 1'b0);
    step(4'd0, 1'b0);
    step(4'd15, 1'b0);
    check("R11 no-op result", int'(res_bit), 1);
    check("R11 no-op carry", int'(carry_bit), 1);

    // R7: serial words, including wrap-around
    serial8(8'd200, 8'd100, 1'b0);
    serial8(8'd255, 8'd1,   1'b0);
    serial8(8'd128, 8'd128, 1'b0);
    serial8(8'd0,   8'd0,   1'b0);
    serial8(8'd5,   8'd9,   1'b1);
    serial8(8'd0,   8'd1,   1'b1);
    serial8(8'd77,  8'd77,  1'b1);
    serial8(8'd200, 8'd55,  1'b1);

    // R1: reset beats an offered step
    step(4'd1, 1'b1);
    step(4'd11, 1'b0);
    @(posedge clk); #2;
    rst = 1'b1; op_valid = 1'b1; op_code = 4'd9; bus_bit = 1'b1;
    @(negedge clk); #2;
    check("R1 mid-run result", int'(res_bit), 0);
    check("R1 mid-run carry", int'(carry_bit), 0);
    check("R1 mid-run carry_oe", int'(carry_oe), 0);
    op_valid = 1'b0; rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule